// File: doc/BRIEF.md
# Selectable-Polynomial Nonce and Random-Bit Generator

This block supplies the pseudo-random values that the transmit side of a backplane Ethernet auto-negotiation engine places in its base link codeword. It has two registers that step together. The first is a 7-bit linear feedback shift register (LFSR). Its most significant bit is the single random bit carried in codeword position 49. The second is an 8-bit LFSR, and its low bits form the nonce field.

Both registers are loaded from an external 8-bit seed whenever negotiation restarts, whatever state the generator is in. After that they advance by exactly one step in each cycle in which the advance strobe is high. A select input picks one of two primitive feedback polynomials for the random-bit register. The select can change at run time. A change alters nothing until the next step, which then uses the new polynomial. A seed that would leave either register all zero is replaced by the value 1 in that register, so that neither register can lock up.

Top module: `nonce_gen`

## Requirements
- R1: While rstN is low, and at the first clock edge after it, the random register holds 7'h01 and the nonce register holds 8'h01. The outputs then read nonceOut = 5'h01 and randBit = 0.
- R2: At a clock edge where restart is high, the random register loads seed[6:0] and the nonce register loads seed[7:0]. The outputs show the loaded values from that edge on.
- R3: When a loaded value would be all zero, the register it belongs to loads 1 instead. Each register is handled separately. Neither register ever holds zero.
- R4: At an edge where advance is high and restart is low, and polySel = 1, the random register shifts left by one. Bit 0 takes the feedback bit[6] XOR bit[5], which is the polynomial x^7+x^6+1.
- R5: At such an advance edge with polySel = 0, the feedback is bit[6] XOR bit[2], which is the polynomial x^7+x^3+1.
- R6: At every advance edge, the nonce register also shifts left. Bit 0 takes the feedback bit[7] XOR bit[5] XOR bit[4] XOR bit[3]. The output randBit is bit 6 of the random register, and nonceOut is bits [4:0] of the nonce register.
- R7: When neither restart nor advance is high, both registers hold their values. This includes any cycle in which polySel changes.
- R8: When restart and advance are high in the same cycle, restart wins. The registers load the seed and do not step.
- R9: From any non-zero state, under either polySel value, the randBit stream repeats with a period of exactly 127 advance steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| seed | input | 8 | Seed for both registers |
| polySel | input | 1 | Feedback polynomial select for the random register |
| restart | input | 1 | Reload both registers from seed |
| advance | input | 1 | Step both registers once |
| nonceOut | output | 5 | Nonce field |
| randBit | output | 1 | Random bit for codeword position 49 |

## Verification
The bench builds the block with its default parameters: a 7-bit random register with tap masks 7'h60 and 7'h44, and an 8-bit nonce register with tap mask 8'hB8 and a 5-bit field. With these sizes, a full 127-step cycle of the random register can be run twice under each polynomial and compared with an independent model at every step. A seed of 8'h80 clears only the random register, and a seed of 8'h00 clears both. Together they reach the case where one register is forced to 1 and the case where both are.

// File: rtl/nonce_gen_pkg.sv
package nonce_gen_pkg;

  typedef struct packed {
    logic load;
    logic step;
  } genStrobes_t;

endpackage

// File: rtl/nonce_gen_ctrl.sv
module nonce_gen_ctrl
  import nonce_gen_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        restart,
  input  logic        advance,
  output genStrobes_t strobes
);

  always_comb begin
    strobes.load = restart;
    strobes.step = advance & ~restart;
  end

  AST_RESTART_WINS: assert property (@(posedge clk) disable iff (!rstN)
    restart |-> !strobes.step); // R8

endmodule

// File: rtl/nonce_gen_datapath.sv
module nonce_gen_datapath
  import nonce_gen_pkg::*;
#(
  parameter int RAND_W = 7,
  parameter int SEED_W = 8,
  parameter int NONCE_W = 5,
  parameter logic [RAND_W-1:0] TAPS_HI = 7'h60,
  parameter logic [RAND_W-1:0] TAPS_LO = 7'h44,
  parameter logic [SEED_W-1:0] NONCE_TAPS = 8'hB8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SEED_W-1:0]  seed,
  input  logic               polySel,
  input  genStrobes_t        strobes,
  output logic [NONCE_W-1:0] nonceOut,
  output logic               randBit
);

  localparam logic [RAND_W-1:0] RAND_ONE  = RAND_W'(1);
  localparam logic [SEED_W-1:0] NONCE_ONE = SEED_W'(1);

  logic [RAND_W-1:0] randReg, randNext, randSeed, randMask;
  logic [SEED_W-1:0] nonceReg, nonceNext, nonceSeed;
  logic [SEED_W-1:0] nonceTerms;
  logic randFb, nonceFb;

  always_comb begin
    randSeed  = (seed[RAND_W-1:0] == '0) ? RAND_ONE : seed[RAND_W-1:0];
    nonceSeed = (seed == '0) ? NONCE_ONE : seed;
  end

  always_comb begin
    randMask = polySel ? TAPS_HI : TAPS_LO;
    randFb   = ^(randReg & randMask);
  end

  for (genvar i = 0; i < SEED_W; i++) begin : g_nonceTap
    if (NONCE_TAPS[i]) begin : g_on
      assign nonceTerms[i] = nonceReg[i];
    end else begin : g_off
      assign nonceTerms[i] = 1'b0;
    end
  end
  assign nonceFb = ^nonceTerms;

  always_comb begin
    randNext  = randReg;
    nonceNext = nonceReg;
    if (strobes.load) begin
      randNext  = randSeed;
      nonceNext = nonceSeed;
    end else if (strobes.step) begin
      randNext  = {randReg[RAND_W-2:0], randFb};
      nonceNext = {nonceReg[SEED_W-2:0], nonceFb};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      randReg  <= RAND_ONE;
      nonceReg <= NONCE_ONE;
    end else begin
      randReg  <= randNext;
      nonceReg <= nonceNext;
    end
  end

  assign randBit  = randReg[RAND_W-1];
  assign nonceOut = nonceReg[NONCE_W-1:0];

  AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (randReg != '0) && (nonceReg != '0)); // R3

  AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(strobes.load) |->
      (randReg == (($past(seed[RAND_W-1:0]) == '0) ? RAND_ONE : $past(seed[RAND_W-1:0])))); // R2

  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && !$past(strobes.load) && !$past(strobes.step) |->
      $stable(randReg) && $stable(nonceReg)); // R7

  AST_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(strobes.step) |->
      (randReg[RAND_W-1:1] == $past(randReg[RAND_W-2:0]))); // R4

endmodule

// File: rtl/nonce_gen.sv
module nonce_gen
  import nonce_gen_pkg::*;
#(
  parameter int RAND_W = 7,
  parameter int SEED_W = 8,
  parameter int NONCE_W = 5,
  parameter logic [RAND_W-1:0] TAPS_HI = 7'h60,
  parameter logic [RAND_W-1:0] TAPS_LO = 7'h44,
  parameter logic [SEED_W-1:0] NONCE_TAPS = 8'hB8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SEED_W-1:0]  seed,
  input  logic               polySel,
  input  logic               restart,
  input  logic               advance,
  output logic [NONCE_W-1:0] nonceOut,
  output logic               randBit
);

  genStrobes_t strobes;

  nonce_gen_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .restart (restart),
    .advance (advance),
    .strobes (strobes)
  );

  nonce_gen_datapath #(
    .RAND_W     (RAND_W),
    .SEED_W     (SEED_W),
    .NONCE_W    (NONCE_W),
    .TAPS_HI    (TAPS_HI),
    .TAPS_LO    (TAPS_LO),
    .NONCE_TAPS (NONCE_TAPS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .seed     (seed),
    .polySel  (polySel),
    .strobes  (strobes),
    .nonceOut (nonceOut),
    .randBit  (randBit)
  );

endmodule

// File: tb/nonce_gen_bench.sv
`timescale 1ns/1ps
module nonce_gen_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] seed = 8'h00;
  logic polySel = 1'b0;
  logic restart = 1'b0;
  logic advance = 1'b0;
  logic [4:0] nonceOut;
  logic randBit;

  int checks = 0;
  int fails = 0;
  logic [6:0] mRand;
  logic [7:0] mNonce;
  logic seqBits [0:253];

  always #2.5 clk = ~clk;

  nonce_gen u_nonce_gen (
    .clk(clk), .rstN(rstN), .seed(seed), .polySel(polySel),
    .restart(restart), .advance(advance), .nonceOut(nonceOut), .randBit(randBit)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void modelLoad(input logic [7:0] s);
    mRand  = (s[6:0] == 7'h0) ? 7'h01 : s[6:0];
    mNonce = (s == 8'h0) ? 8'h01 : s;
  endfunction

  function automatic void modelStep(input logic sel);
    logic fr, fn;
    fr = sel ? (mRand[6] ^ mRand[5]) : (mRand[6] ^ mRand[2]);
    fn = mNonce[7] ^ mNonce[5] ^ mNonce[4] ^ mNonce[3];
    mRand  = {mRand[5:0], fr};
    mNonce = {mNonce[6:0], fn};
  endfunction

  task automatic compareOut(input string tag);
    check(randBit == mRand[6], tag, 32'(randBit), 32'(mRand[6]));
    check(nonceOut == mNonce[4:0], tag, 32'(nonceOut), 32'(mNonce[4:0]));
  endtask

  // one clock with the given strobes; inputs set at negedge, sampled at next negedge
  task automatic cycle(input logic rs, input logic adv);
    restart = rs;
    advance = adv;
    @(negedge clk);
    if (rs) modelLoad(seed);
    else if (adv) modelStep(polySel);
    restart = 1'b0;
    advance = 1'b0;
  endtask

  task automatic t_reset;
    rstN = 1'b0;
    restart = 1'b1;
    advance = 1'b1;
    repeat (3) @(negedge clk);
    restart = 1'b0;
    advance = 1'b0;
    mRand = 7'h01;
    mNonce = 8'h01;
    compareOut("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    compareOut("R1 after reset");
  endtask

  task automatic t_seedLoad;
    seed = 8'hA5;
    cycle(1'b1, 1'b0);
    check(mRand == 7'h25, "R2 model", 32'(mRand), 32'h25);
    compareOut("R2 seed load A5");
    seed = 8'h3C;
    cycle(1'b1, 1'b0);
    compareOut("R2 seed load 3C");
  endtask

  task automatic t_zeroSeed;
    seed = 8'h80;
    cycle(1'b1, 1'b0);
    compareOut("R3 seed 80 forced rand");
    for (int i = 0; i < 7; i++) begin
      cycle(1'b0, 1'b1);
      compareOut("R3 steps after 80");
    end
    seed = 8'h00;
    cycle(1'b1, 1'b0);
    check(nonceOut == 5'h01, "R3 seed 00 nonce", 32'(nonceOut), 32'h01);
    for (int i = 0; i < 8; i++) begin
      cycle(1'b0, 1'b1);
      compareOut("R3 steps after 00");
    end
  endtask

  task automatic t_sequence(input logic sel, input logic [7:0] s, input string tag);
    polySel = sel;
    seed = s;
    cycle(1'b1, 1'b0);
    for (int i = 0; i < 300; i++) begin
      cycle(1'b0, 1'b1);
      compareOut(tag);
    end
  endtask

  task automatic t_hold;
    logic b0;
    logic [4:0] n0;
    b0 = randBit;
    n0 = nonceOut;
    for (int i = 0; i < 10; i++) begin
      polySel = ~polySel;
      seed = seed + 8'h11;
      cycle(1'b0, 1'b0);
      check(randBit == b0, "R7 hold bit", 32'(randBit), 32'(b0));
      check(nonceOut == n0, "R7 hold nonce", 32'(nonceOut), 32'(n0));
    end
  endtask

  task automatic t_selSwitch;
    seed = 8'h5B;
    polySel = 1'b1;
    cycle(1'b1, 1'b0);
    for (int i = 0; i < 40; i++) begin
      if (i % 3 == 0) polySel = ~polySel;
      cycle(1'b0, 1'b1);
      compareOut("R4 R5 runtime switch");
    end
  endtask

  task automatic t_priority;
    seed = 8'h29;
    cycle(1'b0, 1'b1);
    cycle(1'b0, 1'b1);
    cycle(1'b1, 1'b1);
    check(mRand == 7'h29, "R8 model", 32'(mRand), 32'h29);
    compareOut("R8 restart over advance");
  endtask

  task automatic t_period(input logic sel, input string tag);
    int ones;
    int mism;
    polySel = sel;
    seed = 8'h47;
    cycle(1'b1, 1'b0);
    for (int i = 0; i < 254; i++) begin
      cycle(1'b0, 1'b1);
      seqBits[i] = randBit;
    end
    mism = 0;
    ones = 0;
    for (int i = 0; i < 127; i++) begin
      if (seqBits[i] != seqBits[i + 127]) mism++;
      if (seqBits[i]) ones++;
    end
    check(mism == 0, tag, 32'(mism), 32'd0);
    check(ones == 64, tag, 32'(ones), 32'd64);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_seedLoad();
    t_zeroSeed();
    t_sequence(1'b1, 8'hC3, "R4 R6 sequence sel1");
    t_sequence(1'b0, 8'h9E, "R5 R6 sequence sel0");
    t_hold();
    t_selSwitch();
    t_priority();
    t_period(1'b1, "R9 period sel1");
    t_period(1'b0, "R9 period sel0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule